// File: doc/BRIEF.md
# Synchronous Burst PSRAM Bus Controller

This block is the host-side engine for synchronous burst transfers on a clocked, NOR-compatible pseudo-static RAM bus. A host asks for one burst at a time. It gives a start address, a word count, a direction and a 16-bit bus-setup word. The controller checks the setup word, drives one address strobe, and waits out the configured latency. It then moves one 16-bit word per clock, stalling while the device signals WAIT. Chip enable is released as soon as the requested count is done. The memory clock is the controller clock, forwarded outside this block.

Behaviour is decoded at run time from the setup word. Bit 15 is the mode, and only 0 (synchronous burst) is accepted. Bits 13:11 are the latency code. Bit 14 chooses fixed latency. Bit 10 is the WAIT polarity and bit 8 the WAIT timing. Bit 3 set disables wrap. Bits 2:0 are the burst length. Each transferred word is tagged with the word address it belongs to. A built-in chip-enable timer cuts a burst short before the device's maximum chip-enable-low time would be exceeded.

The state machine has five states: `ST_IDLE`, `ST_ADDR`, `ST_LAT`, `ST_XFER` and `ST_END`. Its transitions are:
- IDLE→ADDR on an accepted start; IDLE→IDLE on a rejected start.
- ADDR→LAT always.
- LAT→XFER when the latency count expires; LAT→END when the guard trips.
- XFER→END after the last word, or when the guard trips; XFER→XFER otherwise.
- END→IDLE always.

Top module: `pbus_burst_ctl`

## Requirements
- R1: While and after reset, all bus strobes (`mem_ce_n`, `mem_adv_n`, `mem_oe_n`, `mem_we_n`) are high, `mem_dq_oe`, `busy`, `done`, `err` and `xfer_ack` are low.
- R2: A start is rejected, with `err` high for exactly the cycle after the start edge and chip enable left high, when any of these holds: setup bit 15 is 1 (asynchronous mode), the latency code in bits 13:11 is 0, 1 or 7, bits 2:0 are not one of 001/010/011/100/111, or the word count is zero.
- R3: An accepted start yields one address cycle (cycle 0) with `mem_ce_n` and `mem_adv_n` low, `mem_addr` equal to the start address, `mem_oe_n` high and `mem_we_n` low exactly when the burst is a write; ADV is low for that single cycle only.
- R4: The latency is the code L in bits 13:11 when bit 14 is 0 (variable), and 2·L when bit 14 is 1 (fixed). Without stalls, word i is moved in cycle 1+latency+i, counting the address cycle as cycle 0. WAIT is ignored during the latency cycles.
- R5: With bit 10 = 1, WAIT is asserted at a high level; with bit 10 = 0, it is asserted at a low level.
- R6: With bit 8 = 0, a cycle in which WAIT is asserted moves no word. With bit 8 = 1, the cycle after an asserted WAIT moves no word.
- R7: On a read, `mem_oe_n` is low through latency and transfer. A word sampled from `mem_dq_in` in a transfer cycle appears on `rd_data` with `xfer_ack` high in the next cycle.
- R8: On a write, `wr_take` is high in each transfer cycle, `mem_dq_out` carries `wr_data`, `mem_dq_oe` is high through the transfer state, and `mem_oe_n` stays high.
- R9: The tag of each word starts at the start address. Burst-length codes are 001=4, 010=8, 011=16, 100=32 and 111=continuous words. With bit 3 = 0 and a fixed length, the tag wraps inside the aligned block of that length; otherwise it counts up linearly.
- R10: After the last requested word, chip enable goes high for one cycle with `done` high, then the block is idle. Exactly the requested number of `xfer_ack` pulses have occurred.
- R11: Chip enable never stays low for more than CEM_LIMIT−GUARD+1 cycles. When the low-cycle count reaches CEM_LIMIT−GUARD, the burst ends without moving a word in that cycle, and `trunc` is high together with `done`; otherwise `trunc` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Burst request, sampled in idle |
| start_write | input | 1 | 1 = write burst, 0 = read burst |
| start_addr | input | ADDR_W | First word address |
| start_count | input | CNT_W | Number of words to move |
| cfg_word | input | 16 | Bus-setup word |
| wr_data | input | 16 | Write word for the current transfer cycle |
| wr_take | output | 1 | Write word consumed this cycle |
| rd_data | output | 16 | Captured read word |
| xfer_ack | output | 1 | One word moved in the previous cycle |
| xfer_tag | output | ADDR_W | Word address of the acknowledged word |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | Burst finished pulse |
| trunc | output | 1 | Burst was cut by the chip-enable guard |
| err | output | 1 | Start rejected pulse |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_adv_n | output | 1 | Address valid strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ADDR_W | Address bus |
| mem_dq_out | output | 16 | Data driven to the device |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Data from the device |
| mem_wait | input | 1 | Device flow-control signal |

## Verification
The bench models the device so that each data word is derived from the number of chip-enable-low cycles elapsed. Any read word or write-strobe timing therefore shows exactly which cycle it belongs to. Reads with variable and fixed latency at several codes separate the two latency rules. Single WAIT pulses at both polarities, with both timings, show whether the stall lands on the right cycle. Bursts from an address near a block edge, with wrap on and off, expose the tag arithmetic. Rejected setups, a zero count, and a very long continuous read check the error path and the chip-enable cut-off.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_LAT,
        ST_XFER,
        ST_END
    } pbus_state_e;

    localparam int SETUP_W    = 16;
    localparam int MASK_W     = 5;
    localparam int LAT_W      = 4;
    localparam int B_MODE     = 15;
    localparam int B_FIXED    = 14;
    localparam int B_LAT_HI   = 13;
    localparam int B_LAT_LO   = 11;
    localparam int B_WPOL     = 10;
    localparam int B_WEARLY   = 8;
    localparam int B_NOWRAP   = 3;

    typedef struct packed {
        logic              ok;
        logic [LAT_W-1:0]  lat_cycles;
        logic              wait_hi;
        logic              wait_early;
        logic [MASK_W-1:0] wrap_mask;
    } pbus_setup_t;

endpackage

// File: rtl/pbus_cfg_decode.sv
module pbus_cfg_decode
    import pbus_pkg::*;
(
    input  logic [SETUP_W-1:0] setup,
    output pbus_setup_t        dec
);
    logic [2:0]        code;
    logic [2:0]        len_sel;
    logic              code_ok;
    logic              len_ok;
    logic [MASK_W-1:0] len_mask;

    assign code    = setup[B_LAT_HI:B_LAT_LO];
    assign len_sel = setup[2:0];
    assign code_ok = (code >= 3'd2) && (code <= 3'd6);

    always_comb begin
        len_ok   = 1'b1;
        len_mask = '0;
        unique case (len_sel)
            3'b001:  len_mask = 5'd3;
            3'b010:  len_mask = 5'd7;
            3'b011:  len_mask = 5'd15;
            3'b100:  len_mask = 5'd31;
            3'b111:  len_mask = 5'd0;
            default: len_ok   = 1'b0;
        endcase
    end

    always_comb begin
        dec.ok         = !setup[B_MODE] && code_ok && len_ok;
        dec.lat_cycles = setup[B_FIXED] ? {code, 1'b0} : {1'b0, code};
        dec.wait_hi    = setup[B_WPOL];
        dec.wait_early = setup[B_WEARLY];
        dec.wrap_mask  = setup[B_NOWRAP] ? '0 : len_mask;
    end
endmodule

// File: rtl/pbus_tag_ctr.sv
module pbus_tag_ctr #(
    parameter int ADDR_W = 23,
    parameter int MASK_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    input  logic [MASK_W-1:0] wrap_mask,
    output logic [ADDR_W-1:0] tag
);
    logic [ADDR_W-1:0] mask_ext;
    logic [ADDR_W-1:0] inc;
    logic [ADDR_W-1:0] tag_next;

    assign mask_ext = ADDR_W'(wrap_mask);
    assign inc      = tag + 1'b1;
    assign tag_next = (mask_ext == '0) ? inc : ((tag & ~mask_ext) | (inc & mask_ext));

    always_ff @(posedge clk) begin
        if (rst)       tag <= '0;
        else if (load) tag <= load_addr;
        else if (step) tag <= tag_next;
    end

    AST_WRAP_KEEPS_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (step && !load && wrap_mask != '0) |=>
        ((tag & ~ADDR_W'($past(wrap_mask))) == ($past(tag) & ~ADDR_W'($past(wrap_mask))))); // R9
endmodule

// File: rtl/pbus_cel_guard.sv
module pbus_cel_guard #(
    parameter int CEM_LIMIT = 500,
    parameter int GUARD     = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    output logic near
);
    localparam int CW = $clog2(CEM_LIMIT + 1);
    localparam logic [CW-1:0] TRIP = CW'(CEM_LIMIT - GUARD);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || ce_n) low_cnt <= '0;
        else             low_cnt <= low_cnt + 1'b1;
    end

    assign near = (low_cnt >= TRIP);

    AST_CE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        low_cnt < CW'(CEM_LIMIT)); // R11
endmodule

// File: rtl/pbus_burst_ctl.sv
module pbus_burst_ctl
    import pbus_pkg::*;
#(
    parameter int ADDR_W    = 23,
    parameter int CNT_W     = 12,
    parameter int CEM_LIMIT = 500,
    parameter int GUARD     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_write,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_count,
    input  logic [15:0]       cfg_word,
    input  logic [15:0]       wr_data,
    output logic              wr_take,
    output logic [15:0]       rd_data,
    output logic              xfer_ack,
    output logic [ADDR_W-1:0] xfer_tag,
    output logic              busy,
    output logic              done,
    output logic              trunc,
    output logic              err,
    output logic              mem_ce_n,
    output logic              mem_adv_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [15:0]       mem_dq_in,
    input  logic              mem_wait
);
    pbus_state_e         state_q, state_d;
    logic [SETUP_W-1:0]  setup_q;
    logic [LAT_W-1:0]    lat_cnt;
    logic [CNT_W-1:0]    remain;
    logic                is_wr;
    logic                cut_q;
    logic                wait_q;
    pbus_setup_t         dec;
    logic [ADDR_W-1:0]   tag;
    logic                near;
    logic                accept;
    logic                wait_act;
    logic                stall;
    logic                fire;

    pbus_cfg_decode u_dec (
        .setup (state_q == ST_IDLE ? cfg_word : setup_q),
        .dec   (dec)
    );

    assign accept   = start && dec.ok && (start_count != '0);
    assign wait_act = dec.wait_hi ? mem_wait : !mem_wait;
    assign stall    = dec.wait_early ? wait_q : wait_act;
    assign fire     = (state_q == ST_XFER) && !near && !stall;

    pbus_tag_ctr #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_tag (
        .clk       (clk),
        .rst       (rst),
        .load      ((state_q == ST_IDLE) && accept),
        .load_addr (start_addr),
        .step      (fire),
        .wrap_mask (dec.wrap_mask),
        .tag       (tag)
    );

    pbus_cel_guard #(.CEM_LIMIT(CEM_LIMIT), .GUARD(GUARD)) u_guard (
        .clk  (clk),
        .rst  (rst),
        .ce_n (mem_ce_n),
        .near (near)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_ADDR;
            ST_ADDR: state_d = ST_LAT;
            ST_LAT:  if (near) state_d = ST_END;
                     else if (lat_cnt == '0) state_d = ST_XFER;
            ST_XFER: if (near) state_d = ST_END;
                     else if (fire && remain == CNT_W'(1)) state_d = ST_END;
            ST_END:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and burst bookkeeping
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            setup_q <= '0;
            lat_cnt <= '0;
            remain  <= '0;
            is_wr   <= 1'b0;
            cut_q   <= 1'b0;
            wait_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            wait_q  <= wait_act;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    setup_q <= cfg_word;
                    remain  <= start_count;
                    is_wr   <= start_write;
                    cut_q   <= 1'b0;
                end
                ST_ADDR: lat_cnt <= dec.lat_cycles - LAT_W'(1);
                ST_LAT: begin
                    if (lat_cnt != '0) lat_cnt <= lat_cnt - 1'b1;
                    if (near) cut_q <= 1'b1;
                end
                ST_XFER: begin
                    if (near)      cut_q  <= 1'b1;
                    else if (fire) remain <= remain - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // bus outputs
    always_comb begin
        mem_ce_n  = 1'b1;
        mem_adv_n = 1'b1;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_addr  = '0;
        mem_dq_oe = 1'b0;
        unique case (state_q)
            ST_ADDR: begin
                mem_ce_n  = 1'b0;
                mem_adv_n = 1'b0;
                mem_we_n  = !is_wr;
                mem_addr  = tag;
            end
            ST_LAT: begin
                mem_ce_n = 1'b0;
                mem_oe_n = is_wr;
            end
            ST_XFER: begin
                mem_ce_n  = 1'b0;
                mem_oe_n  = is_wr;
                mem_dq_oe = is_wr;
            end
            default: ;
        endcase
    end

    assign mem_dq_out = wr_data;
    assign wr_take    = fire && is_wr;
    assign busy       = (state_q != ST_IDLE);

    // host-side pulses
    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_ack <= 1'b0;
            xfer_tag <= '0;
            rd_data  <= '0;
            done     <= 1'b0;
            trunc    <= 1'b0;
            err      <= 1'b0;
        end else begin
            xfer_ack <= fire;
            if (fire) xfer_tag <= tag;
            if (fire && !is_wr) rd_data <= mem_dq_in;
            done  <= (state_q == ST_END);
            trunc <= (state_q == ST_END) && cut_q;
            err   <= (state_q == ST_IDLE) && start && !accept;
        end
    end

    AST_ADV_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_adv_n) |=> mem_adv_n); // R3
    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        err |-> (mem_ce_n && !busy)); // R2
    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe); // R8
    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        done |-> (mem_ce_n && !xfer_ack)); // R10
    AST_ACK_AFTER_XFER: assert property (@(posedge clk) disable iff (rst)
        xfer_ack |-> $past(state_q == ST_XFER)); // R7
endmodule

// File: tb/test_pbus_burst_ctl.sv
module test_pbus_burst_ctl;
    localparam int ADDR_W = 23;
    localparam int CNT_W  = 12;
    localparam int LIMIT  = 500;
    localparam int GUARD  = 4;
    localparam int NVEC   = 10;

    // row: {setup[15:0], addr[15:0], count[7:0], write, stall_cycle[7:0]}
    localparam logic [48:0] VEC [NVEC] = '{
        {16'h1D0F, 16'h0010, 8'd4,  1'b0, 8'd0},
        {16'h5D0F, 16'h0020, 8'd3,  1'b0, 8'd0},
        {16'h140F, 16'h0030, 8'd5,  1'b0, 8'd4},
        {16'h150F, 16'h0030, 8'd5,  1'b0, 8'd4},
        {16'h210F, 16'h0050, 8'd4,  1'b0, 8'd7},
        {16'h1D01, 16'h000E, 8'd6,  1'b0, 8'd0},
        {16'h1D09, 16'h000E, 8'd6,  1'b0, 8'd0},
        {16'h1D0F, 16'h0040, 8'd4,  1'b1, 8'd6},
        {16'h1D02, 16'h003D, 8'd10, 1'b1, 8'd0},
        {16'h350F, 16'h0070, 8'd2,  1'b0, 8'd0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic start_write = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [CNT_W-1:0]  start_count = '0;
    logic [15:0] cfg_word = 16'h8000;
    logic [15:0] wr_data = 16'hB000;
    logic wr_take, xfer_ack, busy, done, trunc, err;
    logic [15:0] rd_data, mem_dq_out, mem_dq_in;
    logic [ADDR_W-1:0] xfer_tag, mem_addr;
    logic mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_dq_oe, mem_wait;

    logic [15:0] cyc = '0;
    logic        wait_pol = 1'b1;
    logic [15:0] wait_at = '0;
    int n_checks = 0;
    int n_fail = 0;
    int max_cyc;

    always #4 clk = !clk;

    always_ff @(posedge clk) cyc <= mem_ce_n ? 16'd0 : cyc + 16'd1;
    assign mem_dq_in = 16'hD000 + cyc;
    assign mem_wait  = wait_pol ? (wait_at != 0 && cyc == wait_at)
                                : !(wait_at != 0 && cyc == wait_at);

    pbus_burst_ctl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CEM_LIMIT(LIMIT), .GUARD(GUARD)) i_pbus_burst_ctl (
        .clk(clk), .rst(rst), .start(start), .start_write(start_write),
        .start_addr(start_addr), .start_count(start_count), .cfg_word(cfg_word),
        .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .xfer_ack(xfer_ack),
        .xfer_tag(xfer_tag), .busy(busy), .done(done), .trunc(trunc), .err(err),
        .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_wait(mem_wait)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int lat_of(input logic [15:0] s);
        return s[14] ? 2 * int'(s[13:11]) : int'(s[13:11]);
    endfunction

    function automatic int tag_next(input int t, input logic [15:0] s);
        int m;
        case (s[2:0])
            3'b001: m = 3;
            3'b010: m = 7;
            3'b011: m = 15;
            3'b100: m = 31;
            default: m = 0;
        endcase
        if (s[3] || m == 0) return t + 1;
        return (t & ~m) | ((t + 1) & m);
    endfunction

    function automatic int beat_cyc(input int lat, input int i, input int stall);
        int c;
        c = 1 + lat + i;
        if (stall != 0 && c >= stall) c++;
        return c;
    endfunction

    task automatic run_burst(input logic [15:0] s, input int addr, input int n, input bit wr,
                             input int stall, input bit expect_cut);
        int lat, acks, takes, exp_tag, c, exp_n;
        string lbl;
        lat = lat_of(s);
        if (s[10] == 1'b0) lbl = "R5";
        else if (stall != 0) lbl = "R6";
        else if (s[14]) lbl = "R4";
        else lbl = "R7";
        exp_n = expect_cut ? (LIMIT - GUARD - 1 - lat) : n;
        @(negedge clk);
        cfg_word = s; start_addr = ADDR_W'(addr); start_count = CNT_W'(n);
        start_write = wr; wait_pol = s[10];
        wait_at = (stall == 0) ? 16'd0 : (s[8] ? 16'(stall - 1) : 16'(stall));
        wr_data = 16'hB000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!mem_ce_n && !mem_adv_n && mem_oe_n && mem_we_n == !wr && int'(mem_addr) == addr,
              "R3", "address cycle addr", int'(mem_addr), addr);
        acks = 0; takes = 0; exp_tag = addr; max_cyc = 0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (!mem_ce_n && int'(cyc) > max_cyc) max_cyc = int'(cyc);
            if (wr_take) begin
                c = beat_cyc(lat, takes, stall);
                check(int'(cyc) == c, stall != 0 ? "R6" : "R4", "write beat cycle", int'(cyc), c);
                check(mem_dq_out == wr_data && mem_dq_oe && mem_oe_n, "R8", "write data",
                      int'(mem_dq_out), int'(wr_data));
                takes++;
                wr_data = 16'hB000 + 16'(takes);
            end
            if (xfer_ack) begin
                check(int'(xfer_tag) == exp_tag, "R9", "word tag", int'(xfer_tag), exp_tag);
                if (!wr) begin
                    c = beat_cyc(lat, acks, stall);
                    check(int'(rd_data) == 16'hD000 + c, lbl, "read word", int'(rd_data), 16'hD000 + c);
                end
                exp_tag = tag_next(exp_tag, s);
                acks++;
            end
            if (done) begin
                check(acks == exp_n, expect_cut ? "R11" : "R10", "word count", acks, exp_n);
                check(mem_ce_n && trunc == expect_cut, expect_cut ? "R11" : "R10", "end flags",
                      int'(trunc), int'(expect_cut));
                @(negedge clk);
                check(!busy && mem_ce_n, "R10", "idle after end", int'(busy), 0);
                break;
            end
        end
        wait_at = '0; wait_pol = 1'b1;
    endtask

    task automatic try_bad(input logic [15:0] s, input int n);
        @(negedge clk);
        cfg_word = s; start_count = CNT_W'(n); start_addr = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(err && mem_ce_n && !busy, "R2", "reject pulse", int'(err), 1);
        @(negedge clk);
        check(!err && mem_ce_n && !busy, "R2", "reject single", int'(err), 0);
    endtask

    initial begin
        #(8 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog R10 actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(mem_ce_n && mem_adv_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1", "strobes in reset",
              {mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n}, 4'hF);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !err && !xfer_ack && mem_ce_n, "R1", "idle after reset", int'(busy), 0);

        for (int v = 0; v < NVEC; v++) begin
            run_burst(VEC[v][48:33], int'(VEC[v][32:17]), int'(VEC[v][16:9]), VEC[v][8],
                      int'(VEC[v][7:0]), 1'b0);
        end

        try_bad(16'h9D0F, 4);   // R2 asynchronous mode
        try_bad(16'h0D0F, 4);   // R2 latency code 1
        try_bad(16'h3D0F, 4);   // R2 latency code 7
        try_bad(16'h1D08, 4);   // R2 length 000
        try_bad(16'h1D0D, 4);   // R2 length 101
        try_bad(16'h1D0F, 0);   // R2 zero count

        // R11: long continuous read cut by chip-enable guard
        run_burst(16'h1D0F, 16'h0100, 1000, 1'b0, 0, 1'b1);
        check(max_cyc == LIMIT - GUARD, "R11", "last CE-low cycle", max_cyc, LIMIT - GUARD);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule